// File: doc/BRIEF.md
# Trigger Channel Router

A register-programmed trigger router. Eight trigger inputs feed four broadcast channels, and four channels feed eight trigger outputs. Each input has a mask that chooses the channels it drives. Each output has a mask that chooses the channels it listens to. An output that fires stays high until software clears it through an acknowledge register.

Software reaches the block over a plain 32-bit register bus: address, write strobe, write data, and read data that is combinational from the address. Register writes are blocked behind a key. Out of reset the block is locked. Only the lock-access register accepts writes until the key has been written to it.

Top module: `trig_router`

## Requirements
- R1: After reset the block is locked and disabled, every channel mask is 0 and every trigger output is low.
- R2: Writing 0xC5ACCE55 to offset 0xFB0 unlocks the block. Writing any other value there locks it. Reads of 0xFB0 return 0.
- R3: Bit 0 of offset 0xFB4 reads 1 while the block is locked and 0 while it is unlocked. All other bits read 0.
- R4: While the block is locked, writes to any offset other than 0xFB0 leave every register unchanged, including the held outputs.
- R5: Bit 0 of offset 0x000 is the global enable and reads back in bit 0. While it is 0, every trigger output is low, and the held state is cleared at the next clock edge.
- R6: The mask for input n is at offset 0x020+4n, in bits [3:0]. Channel c is active while some input n is high and has bit c set in its mask. Offset 0x138 bits [3:0] show the channel activity live.
- R7: The mask for output m is at offset 0x0A0+4m, in bits [3:0]. When the block is enabled and a channel selected by that mask is active, output m goes high after the next clock edge. It then stays high after the inputs fall.
- R8: Writing 1 to bit m of offset 0x010 clears held output m at the next edge. That offset reads 0. If the clear and the set condition arrive in the same cycle, the output stays set.
- R9: Offset 0x130 shows the trigger inputs live in bits [7:0], and 0x134 shows the trigger outputs. Offset 0x13C shows the channel activity while the block is enabled and 0 while it is disabled.
- R10: Reads from any offset not listed above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| trig_in | input | 8 | Trigger inputs |
| trig_out | output | 8 | Held trigger outputs |

## Verification
The bench builds the block with its default values: 8 inputs, 8 outputs, 4 channels and a 12-bit address. At these values the random stimulus can cover every input mask, every output mask and every channel. It also visits unmapped offsets just past each mask bank, where off-by-one errors in the decode would show. The bench draws the lock key on a random share of accesses to the lock register, so the run moves between the locked and unlocked states many times while the outputs are held.

// File: rtl/trig_router.sv
module trig_router #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter int N_CH  = 4,
  parameter int AW    = 12,
  parameter logic [31:0] KEY = 32'hC5AC_CE55
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [N_IN-1:0]  trig_in,
  output logic [N_OUT-1:0] trig_out
);
  localparam int IW = AW - 2;
  localparam logic [AW-1:0] A_CTRL  = AW'('h000);
  localparam logic [AW-1:0] A_ACK   = AW'('h010);
  localparam logic [AW-1:0] A_INEN  = AW'('h020);
  localparam logic [AW-1:0] A_OUTEN = AW'('h0A0);
  localparam logic [AW-1:0] A_TIN   = AW'('h130);
  localparam logic [AW-1:0] A_TOUT  = AW'('h134);
  localparam logic [AW-1:0] A_CHIN  = AW'('h138);
  localparam logic [AW-1:0] A_CHOUT = AW'('h13C);
  localparam logic [AW-1:0] A_LOCK  = AW'('hFB0);
  localparam logic [AW-1:0] A_LSTAT = AW'('hFB4);

  logic ctrl_en, locked;
  logic [N_IN-1:0][N_CH-1:0]  in_mask;
  logic [N_OUT-1:0][N_CH-1:0] out_mask;
  logic [N_OUT-1:0] hold, set_v, ack_v;
  logic [N_CH-1:0]  ch_in, ch_out;

  wire wr_ok = bus_we && (!locked || bus_addr == A_LOCK);
  wire [AW-1:0] in_off  = bus_addr - A_INEN;
  wire [AW-1:0] out_off = bus_addr - A_OUTEN;
  wire in_hit  = bus_addr[1:0] == 2'b00 && bus_addr >= A_INEN  && int'(in_off[AW-1:2])  < N_IN;
  wire out_hit = bus_addr[1:0] == 2'b00 && bus_addr >= A_OUTEN && int'(out_off[AW-1:2]) < N_OUT;

  assign ack_v = (wr_ok && bus_addr == A_ACK) ? bus_wdata[N_OUT-1:0] : '0;

  always_comb begin
    ch_in = '0;
    for (int n = 0; n < N_IN; n++)
      if (trig_in[n]) ch_in = ch_in | in_mask[n];
  end
  assign ch_out = ctrl_en ? ch_in : '0;

  always_comb
    for (int m = 0; m < N_OUT; m++)
      set_v[m] = |(ch_out & out_mask[m]);

  assign trig_out = ctrl_en ? hold : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      locked  <= 1'b1;
      hold    <= '0;
    end else begin
      hold <= ctrl_en ? ((hold & ~ack_v) | set_v) : '0;
      if (wr_ok && bus_addr == A_CTRL) ctrl_en <= bus_wdata[0];
      if (bus_we && bus_addr == A_LOCK) locked <= bus_wdata != KEY;
    end

  for (genvar n = 0; n < N_IN; n++) begin : g_in
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) in_mask[n] <= '0;
      else if (wr_ok && in_hit && in_off[AW-1:2] == IW'(n)) in_mask[n] <= bus_wdata[N_CH-1:0];
  end

  for (genvar m = 0; m < N_OUT; m++) begin : g_out
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) out_mask[m] <= '0;
      else if (wr_ok && out_hit && out_off[AW-1:2] == IW'(m)) out_mask[m] <= bus_wdata[N_CH-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:  bus_rdata[0] = ctrl_en;
      A_TIN:   bus_rdata[N_IN-1:0] = trig_in;
      A_TOUT:  bus_rdata[N_OUT-1:0] = trig_out;
      A_CHIN:  bus_rdata[N_CH-1:0] = ch_in;
      A_CHOUT: bus_rdata[N_CH-1:0] = ch_out;
      A_LSTAT: bus_rdata[0] = locked;
      default: begin
        for (int n = 0; n < N_IN; n++)
          if (in_hit && in_off[AW-1:2] == IW'(n)) bus_rdata[N_CH-1:0] = in_mask[n];
        for (int m = 0; m < N_OUT; m++)
          if (out_hit && out_off[AW-1:2] == IW'(m)) bus_rdata[N_CH-1:0] = out_mask[m];
      end
    endcase
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> trig_out == '0); // R5
  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_we && bus_addr != A_LOCK) |=>
      $stable(in_mask) && $stable(out_mask) && $stable(ctrl_en)); // R4
  AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_LOCK && bus_wdata == KEY) |=> !locked); // R2
  AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_LOCK && bus_wdata != KEY) |=> locked); // R2
  AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && ack_v == '0 && !(bus_we && bus_addr == A_CTRL)) |=>
      ((trig_out & $past(trig_out)) == $past(trig_out))); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && !(bus_we && bus_addr == A_CTRL) && (set_v & ack_v) != '0) |=>
      ((trig_out & $past(set_v & ack_v)) == $past(set_v & ack_v))); // R8
  always_comb if (rst_n && bus_addr == A_LOCK)
    AST_LOCK_READS_ZERO: assert (bus_rdata == '0); // R2
endmodule

// File: tb/trig_router_bench.sv
module trig_router_bench;
  localparam logic [31:0] KEY = 32'hC5AC_CE55;
  logic clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic bus_we = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0] trig_in = '0, trig_out;
  int checks = 0, errors = 0;

  trig_router u_trig_router (.clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata, .trig_in, .trig_out);

  always #4 clk = ~clk;

  logic [3:0] mi [8];
  logic [3:0] mo [8];
  logic men = 0, mlock = 1;
  logic [7:0] mhold = '0;

  function automatic logic [3:0] m_chin(logic [7:0] tin);
    logic [3:0] c = '0;
    for (int n = 0; n < 8; n++) if (tin[n]) c |= mi[n];
    return c;
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a, logic [7:0] tin);
    logic [31:0] r = '0;
    if (a == 12'h000) r[0] = men;
    else if (a == 12'h130) r[7:0] = tin;
    else if (a == 12'h134) r[7:0] = men ? mhold : 8'h0;
    else if (a == 12'h138) r[3:0] = m_chin(tin);
    else if (a == 12'h13C) r[3:0] = men ? m_chin(tin) : 4'h0;
    else if (a == 12'hFB4) r[0] = mlock;
    else if (a >= 12'h020 && a < 12'h040 && a[1:0] == 0) r[3:0] = mi[(a - 12'h020) >> 2];
    else if (a >= 12'h0A0 && a < 12'h0C0 && a[1:0] == 0) r[3:0] = mo[(a - 12'h0A0) >> 2];
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic we, logic [11:0] a, logic [31:0] wd, logic [7:0] tin);
    logic [3:0] ch;
    logic [7:0] setv, ack;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = wd; trig_in = tin;
    #1 check({tag, " read"}, bus_rdata, m_read(a, tin));
    @(posedge clk);
    ch = men ? m_chin(tin) : 4'h0;
    for (int m = 0; m < 8; m++) setv[m] = |(ch & mo[m]);
    ack = (we && !mlock && a == 12'h010) ? wd[7:0] : 8'h0;
    mhold = men ? ((mhold & ~ack) | setv) : 8'h0;
    if (we && !mlock) begin
      if (a == 12'h000) men = wd[0];
      if (a >= 12'h020 && a < 12'h040 && a[1:0] == 0) mi[(a - 12'h020) >> 2] = wd[3:0];
      if (a >= 12'h0A0 && a < 12'h0C0 && a[1:0] == 0) mo[(a - 12'h0A0) >> 2] = wd[3:0];
    end
    if (we && a == 12'hFB0) mlock = wd != KEY;
    #1 check({tag, " out"}, {24'h0, trig_out}, {24'h0, men ? mhold : 8'h0});
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [11:0] alist [14];
    alist = '{12'h000, 12'h010, 12'h020, 12'h03C, 12'h040, 12'h0A0, 12'h0BC,
              12'h0C0, 12'h130, 12'h134, 12'h138, 12'h13C, 12'hFB0, 12'hFB4};
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin mi[i] = 0; mo[i] = 0; end
    #20 rst_n = 1;
    step("R1 lock status", 0, 12'hFB4, 0, 0);
    step("R1 ctrl", 0, 12'h000, 0, 8'hFF);
    step("R1 mask", 0, 12'h0A0, 0, 8'hFF);
    step("R4 locked ctrl write", 1, 12'h000, 1, 0);
    step("R4 locked mask write", 1, 12'h020, 32'hF, 0);
    step("R4 readback", 0, 12'h020, 0, 0);
    step("R2 unlock", 1, 12'hFB0, KEY, 0);
    step("R3 unlocked status", 0, 12'hFB4, 0, 0);
    step("R2 lock reads zero", 0, 12'hFB0, 0, 0);
    step("R6 in mask", 1, 12'h028, 32'hFFFF_FFF2, 0);
    step("R7 out mask", 1, 12'h0B4, 32'h2, 0);
    step("R6 channel before enable", 0, 12'h138, 0, 8'h04);
    step("R9 chout disabled", 0, 12'h13C, 0, 8'h04);
    step("R5 enable", 1, 12'h000, 1, 0);
    step("R7 pulse input 2", 0, 12'h13C, 0, 8'h04);
    step("R7 held after drop", 0, 12'h134, 0, 0);
    step("R9 trig in", 0, 12'h130, 0, 8'hA5);
    step("R8 ack", 1, 12'h010, 32'h20, 0);
    step("R8 ack reads zero", 0, 12'h010, 0, 0);
    step("R8 ack with set", 1, 12'h010, 32'h20, 8'h04);
    step("R8 held", 0, 12'h134, 0, 0);
    step("R5 disable", 1, 12'h000, 0, 8'h04);
    step("R5 quiet", 0, 12'h134, 0, 8'h04);
    step("R5 re-enable", 1, 12'h000, 1, 0);
    step("R5 cleared hold", 0, 12'h134, 0, 0);
    step("R2 relock", 1, 12'hFB0, 32'h1, 0);
    step("R3 locked status", 0, 12'hFB4, 0, 0);
    step("R4 locked ack", 1, 12'h010, 32'hFF, 8'h04);
    step("R4 hold kept", 0, 12'h134, 0, 0);
    step("R10 unmapped", 0, 12'h040, 0, 8'hFF);
    step("R10 unmapped hi", 0, 12'hFFC, 0, 8'hFF);
    for (int i = 0; i < 6000; i++) begin
      logic [11:0] a;
      logic [31:0] wd;
      a = alist[$urandom_range(13)];
      if (a == 12'h020 || a == 12'h0A0) a = a + 12'(4 * $urandom_range(7));
      wd = $urandom;
      if (a == 12'hFB0 && $urandom_range(3) != 0) wd = KEY;
      if (a == 12'h010 && $urandom_range(3) != 0) wd = 0;
      step("R6,R7,R8,R9 random", $urandom_range(2) != 0, a, wd, 8'($urandom) & 8'($urandom));
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule